// File: doc/BRIEF.md
# Wide Register Write Collector

This block takes a stream of 32-bit host writes and turns them into atomic commits for registers that are wider than one write. Wide control registers are 128 bits, or four dwords. Memory words are 64 bits, or two dwords. The block holds the incoming dwords in one holding buffer. It issues a single commit only once every dword of the target has arrived. Plain 32-bit registers bypass the buffer and commit at once.

Descriptor-pointer registers are handled specially. They repeat in every 0x2000-byte page at in-page offsets 0x830 and 0xa10. A write to the top dword of one of these registers always commits. Any low bits that the buffer cannot fully supply are committed as zero. A lower-dword write to such a register is dropped if the buffer is busy with a different register. A dword write to in-page offset 0x420 of page 0 (the timer command slot) commits as a plain write and also empties the buffer; the `TIMER_FLUSH` parameter selects this.

The collector is a two-state machine with states EMPTY and COLLECT. It has seven named transitions:
- START: EMPTY to COLLECT, on the first dword.
- MERGE: COLLECT to COLLECT, on a dword for the same target.
- RESTART: COLLECT to COLLECT, on an ordinary wide write to a new target.
- DROP: no change, on a descriptor lower dword for a foreign target.
- COMPLETE: to EMPTY, when the last needed dword arrives.
- FORCE: to EMPTY, on a descriptor top-dword write.
- FLUSH: to EMPTY, on a timer command write.

Top module: `wide_write_collector`

## Requirements
- R1: After reset no commit is issued. The buffer is empty, so a first descriptor top-dword write commits zeros in bits 95:0.
- R2: Byte addresses below 0x400 are 128-bit registers. Their four dwords, in any order, produce one commit with cmt_size=2 at the 16-byte-aligned address. The commit comes one cycle after the last dword, and no commit comes before it.
- R3: Byte addresses at or above 0xF000 are 64-bit memory words. Two dwords produce one commit with cmt_size=1 at the 8-byte-aligned address, with bits 127:64 zero.
- R4: Any other address not covered by R2, R3 or R11 is a plain register. It commits one cycle after the write with cmt_size=0, the data in bits 31:0 and zeros above. It leaves any collection in progress intact.
- R5: A 128-bit register write to a different aligned address abandons the partial data. Collection restarts at the new address.
- R6: A descriptor top-dword write, with all three lower dwords of that register buffered, commits all 128 bits.
- R7: A descriptor top-dword write with any lower dword missing commits bits 95:0 as zero. The buffer is empty afterwards.
- R8: A descriptor lower-dword write while the buffer holds a different register is discarded, and the buffered contents are kept.
- R9: A write to byte address 0x0420 commits as a plain dword and discards the buffer. The same offset in another page does not discard it.
- R10: Commits are single-cycle strobes, and no commit follows a cycle without a write.
- R11: Descriptor registers sit at in-page offsets 0x830 and 0xa10 in every 0x2000-byte page. Their top dwords are at +0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | ADDR_W (16) | Byte address of the dword |
| wr_data | input | DW (32) | Write data |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_size | output | 2 | 0 dword, 1 64-bit word, 2 128-bit register |
| cmt_addr | output | ADDR_W (16) | Aligned address of the committed register |
| cmt_data | output | DW*WIDE_WORDS (128) | Commit data, low dword in bits 31:0 |

## Verification
Every result is due exactly one clock after the rising edge that accepts a completing write. This holds for all commit kinds: plain, 64-bit, 128-bit, forced descriptor and timer. Writes that only gather data must show no strobe in that same slot. The bench drives each write on a falling edge and reads the commit port on the next falling edge, which lies half a cycle after the registering edge. It then checks the following idle cycle for a deasserted strobe. Dropped and flushed data are observed by finishing the interrupted register afterwards and comparing what the commit carries.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_CSR   = 2'd1,
        K_MEM   = 2'd2,
        K_DESC  = 2'd3
    } tgt_kind_e;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_COLLECT = 1'b1
    } col_state_e;

    localparam logic [1:0] SZ_DWORD = 2'd0;
    localparam logic [1:0] SZ_QWORD = 2'd1;
    localparam logic [1:0] SZ_OWORD = 2'd2;

endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BITS  = 13,
    parameter int WIDE_WORDS = 4,
    parameter int MEM_WORDS  = 2,
    parameter logic [ADDR_W-1:0]    CSR_LIMIT  = 'h0400,
    parameter logic [ADDR_W-1:0]    SRAM_BASE  = 'hF000,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_A = 'h830,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_B = 'hA10,
    parameter logic [PAGE_BITS-1:0] TIMER_OFS  = 'h420,
    parameter bit                   TIMER_FLUSH = 1'b1,
    localparam int IDX_W = $clog2(WIDE_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_kind_e         kind,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  idx,
    output logic              top,
    output logic              flush
);

    localparam int WSH = IDX_W + 2;
    localparam int MSH = $clog2(MEM_WORDS) + 2;
    localparam logic [ADDR_W-1:0] WIDE_ALIGN = ~ADDR_W'((1 << WSH) - 1);
    localparam logic [ADDR_W-1:0] MEM_ALIGN  = ~ADDR_W'((1 << MSH) - 1);
    localparam logic [ADDR_W-1:0] DW_ALIGN   = ~ADDR_W'(3);

    logic [PAGE_BITS-1:0] ofs;
    logic                 desc_hit;
    logic                 page0;

    assign ofs      = addr[PAGE_BITS-1:0];
    assign page0    = (addr[ADDR_W-1:PAGE_BITS] == '0);
    assign desc_hit = (ofs[PAGE_BITS-1:WSH] == DESC_OFS_A[PAGE_BITS-1:WSH]) ||
                      (ofs[PAGE_BITS-1:WSH] == DESC_OFS_B[PAGE_BITS-1:WSH]);

    always_comb begin
        kind = K_PLAIN;
        base = addr & DW_ALIGN;
        idx  = '0;
        if (desc_hit) begin
            kind = K_DESC;
            base = addr & WIDE_ALIGN;
            idx  = addr[WSH-1:2];
        end else if (addr < CSR_LIMIT) begin
            kind = K_CSR;
            base = addr & WIDE_ALIGN;
            idx  = addr[WSH-1:2];
        end else if (addr >= SRAM_BASE) begin
            kind = K_MEM;
            base = addr & MEM_ALIGN;
            idx  = IDX_W'(addr[MSH-1:2]);
        end
    end

    assign top   = desc_hit && (idx == '1);
    assign flush = TIMER_FLUSH && page0 && (ofs == TIMER_OFS);

endmodule

// File: rtl/wwc_collect.sv
module wwc_collect
    import wwc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DW         = 32,
    parameter int WIDE_WORDS = 4,
    parameter int MEM_WORDS  = 2,
    localparam int IDX_W = $clog2(WIDE_WORDS),
    localparam int CW    = DW * WIDE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  tgt_kind_e         kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              top,
    input  logic              flush,
    output logic              cmt_valid,
    output logic [1:0]        cmt_size,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [CW-1:0]     cmt_data
);

    localparam logic [WIDE_WORDS-1:0] FULL_MASK = '1;
    localparam logic [WIDE_WORDS-1:0] MEM_MASK  = WIDE_WORDS'((1 << MEM_WORDS) - 1);

    col_state_e              st_q, st_d;
    logic [ADDR_W-1:0]       tgt_q, tgt_d;
    logic [WIDE_WORDS-1:0]   vm_q, vm_d;
    logic [DW-1:0]           buf_q [WIDE_WORDS];
    logic [DW-1:0]           buf_d [WIDE_WORDS];

    logic [WIDE_WORDS-1:0]   lane_sel;
    logic [WIDE_WORDS-1:0]   merged;
    logic [WIDE_WORDS-1:0]   need;
    logic                    same_tgt;
    logic                    lower_full;

    logic                    c_v;
    logic [1:0]              c_sz;
    logic [ADDR_W-1:0]       c_a;
    logic [CW-1:0]           c_dat;

    for (genvar g = 0; g < WIDE_WORDS; g++) begin : g_lane
        assign lane_sel[g] = (idx == IDX_W'(g));
    end

    assign same_tgt   = (st_q == ST_COLLECT) && (tgt_q == base);
    assign merged     = (same_tgt ? vm_q : '0) | lane_sel;
    assign need       = (kind == K_MEM) ? MEM_MASK : FULL_MASK;
    assign lower_full = same_tgt && (&vm_q[WIDE_WORDS-2:0]);

    // next-state and commit decision
    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        vm_d  = vm_q;
        buf_d = buf_q;
        c_v   = 1'b0;
        c_sz  = SZ_DWORD;
        c_a   = base;
        c_dat = '0;
        if (wr_en) begin
            unique case (kind)
                K_PLAIN: begin
                    c_v   = 1'b1;
                    c_dat = CW'(wr_data);
                    if (flush) begin            // FLUSH
                        st_d = ST_EMPTY;
                        vm_d = '0;
                    end
                end
                K_DESC: begin
                    if (top) begin              // FORCE
                        c_v  = 1'b1;
                        c_sz = SZ_OWORD;
                        for (int i = 0; i < WIDE_WORDS - 1; i++) begin
                            if (lower_full) c_dat[i*DW +: DW] = buf_q[i];
                        end
                        c_dat[CW-1 -: DW] = wr_data;
                        st_d = ST_EMPTY;
                        vm_d = '0;
                    end else if (st_q == ST_EMPTY || same_tgt) begin  // START / MERGE
                        buf_d[idx] = wr_data;
                        vm_d       = merged;
                        tgt_d      = base;
                        st_d       = ST_COLLECT;
                    end
                    // otherwise DROP: nothing changes
                end
                default: begin                  // K_CSR, K_MEM
                    if (merged == need) begin   // COMPLETE
                        c_v  = 1'b1;
                        c_sz = (kind == K_MEM) ? SZ_QWORD : SZ_OWORD;
                        for (int i = 0; i < WIDE_WORDS; i++) begin
                            if (need[i]) c_dat[i*DW +: DW] = lane_sel[i] ? wr_data : buf_q[i];
                        end
                        st_d = ST_EMPTY;
                        vm_d = '0;
                    end else begin              // START / MERGE / RESTART
                        buf_d[idx] = wr_data;
                        vm_d       = merged;
                        tgt_d      = base;
                        st_d       = ST_COLLECT;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_EMPTY;
            tgt_q <= '0;
            vm_q  <= '0;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
            vm_q  <= vm_d;
        end
    end

    always_ff @(posedge clk) begin
        buf_q <= buf_d;
    end

    // commit outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmt_valid <= 1'b0;
            cmt_size  <= SZ_DWORD;
            cmt_addr  <= '0;
            cmt_data  <= '0;
        end else begin
            cmt_valid <= c_v;
            cmt_size  <= c_v ? c_sz  : SZ_DWORD;
            cmt_addr  <= c_v ? c_a   : '0;
            cmt_data  <= c_v ? c_dat : '0;
        end
    end

endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DW         = 32,
    parameter int PAGE_BITS  = 13,
    parameter int WIDE_WORDS = 4,
    parameter int MEM_WORDS  = 2,
    parameter logic [ADDR_W-1:0]    CSR_LIMIT  = 'h0400,
    parameter logic [ADDR_W-1:0]    SRAM_BASE  = 'hF000,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_A = 'h830,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_B = 'hA10,
    parameter logic [PAGE_BITS-1:0] TIMER_OFS  = 'h420,
    parameter bit                   TIMER_FLUSH = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic                     cmt_valid,
    output logic [1:0]               cmt_size,
    output logic [ADDR_W-1:0]        cmt_addr,
    output logic [DW*WIDE_WORDS-1:0] cmt_data
);

    localparam int IDX_W = $clog2(WIDE_WORDS);

    tgt_kind_e         dec_kind;
    logic [ADDR_W-1:0] dec_base;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_top;
    logic              dec_flush;

    wwc_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .WIDE_WORDS (WIDE_WORDS),
        .MEM_WORDS  (MEM_WORDS),
        .CSR_LIMIT  (CSR_LIMIT),
        .SRAM_BASE  (SRAM_BASE),
        .DESC_OFS_A (DESC_OFS_A),
        .DESC_OFS_B (DESC_OFS_B),
        .TIMER_OFS  (TIMER_OFS),
        .TIMER_FLUSH(TIMER_FLUSH)
    ) u_dec (
        .addr  (wr_addr),
        .kind  (dec_kind),
        .base  (dec_base),
        .idx   (dec_idx),
        .top   (dec_top),
        .flush (dec_flush)
    );

    wwc_collect #(
        .ADDR_W     (ADDR_W),
        .DW         (DW),
        .WIDE_WORDS (WIDE_WORDS),
        .MEM_WORDS  (MEM_WORDS)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .kind      (dec_kind),
        .base      (dec_base),
        .idx       (dec_idx),
        .top       (dec_top),
        .flush     (dec_flush),
        .cmt_valid (cmt_valid),
        .cmt_size  (cmt_size),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data)
    );

endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
    parameter int ADDR_W     = 16,
    parameter int DW         = 32,
    parameter int PAGE_BITS  = 13,
    parameter int WIDE_WORDS = 4,
    parameter int MEM_WORDS  = 2,
    parameter logic [ADDR_W-1:0]    CSR_LIMIT  = 'h0400,
    parameter logic [ADDR_W-1:0]    SRAM_BASE  = 'hF000,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_A = 'h830,
    parameter logic [PAGE_BITS-1:0] DESC_OFS_B = 'hA10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DW-1:0]            wr_data,
    input logic                     cmt_valid,
    input logic [1:0]               cmt_size,
    input logic [ADDR_W-1:0]        cmt_addr,
    input logic [DW*WIDE_WORDS-1:0] cmt_data
);

    localparam int CW  = DW * WIDE_WORDS;
    localparam int WSH = $clog2(WIDE_WORDS) + 2;
    localparam int MSH = $clog2(MEM_WORDS) + 2;
    localparam int MDW = DW * MEM_WORDS;

    logic [PAGE_BITS-1:0] w_ofs;
    logic                 w_desc;
    logic                 w_desc_top;
    logic                 w_plain;

    assign w_ofs      = wr_addr[PAGE_BITS-1:0];
    assign w_desc     = (w_ofs[PAGE_BITS-1:WSH] == DESC_OFS_A[PAGE_BITS-1:WSH]) ||
                        (w_ofs[PAGE_BITS-1:WSH] == DESC_OFS_B[PAGE_BITS-1:WSH]);
    assign w_desc_top = w_desc && (&wr_addr[WSH-1:2]);
    assign w_plain    = !w_desc && (wr_addr >= CSR_LIMIT) && (wr_addr < SRAM_BASE);

    // R4
    plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_plain) |=> (cmt_valid && cmt_size == 2'd0 &&
                                cmt_addr == ($past(wr_addr) & ~ADDR_W'(3)) &&
                                cmt_data[DW-1:0] == $past(wr_data)));

    // R4
    dword_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_size == 2'd0) |-> (cmt_data[CW-1:DW] == '0));

    // R6
    desc_top_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w_desc_top) |=> (cmt_valid && cmt_size == 2'd2 &&
                                   cmt_data[CW-1 -: DW] == $past(wr_data)));

    // R3
    qword_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_size == 2'd1) |-> (cmt_data[CW-1:MDW] == '0 &&
                                             cmt_addr[MSH-1:0] == '0));

    // R2
    oword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_size == 2'd2) |-> (cmt_addr[WSH-1:0] == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !cmt_valid);

    // R10
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> (cmt_size != 2'd3));

endmodule

bind wide_write_collector wwc_checker #(
    .ADDR_W     (ADDR_W),
    .DW         (DW),
    .PAGE_BITS  (PAGE_BITS),
    .WIDE_WORDS (WIDE_WORDS),
    .MEM_WORDS  (MEM_WORDS),
    .CSR_LIMIT  (CSR_LIMIT),
    .SRAM_BASE  (SRAM_BASE),
    .DESC_OFS_A (DESC_OFS_A),
    .DESC_OFS_B (DESC_OFS_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmt_valid (cmt_valid),
    .cmt_size  (cmt_size),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data)
);

// File: tb/sim_wide_write_collector.sv
module sim_wide_write_collector;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [15:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         cmt_valid;
    logic [1:0]   cmt_size;
    logic [15:0]  cmt_addr;
    logic [127:0] cmt_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic         got_v;
    logic [1:0]   got_sz;
    logic [15:0]  got_a;
    logic [127:0] got_d;

    always #10 clk = ~clk;   // 50 MHz

    wide_write_collector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmt_valid (cmt_valid),
        .cmt_size  (cmt_size),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one write; commit port sampled on the falling edge after the accepting edge
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        got_v  = cmt_valid;
        got_sz = cmt_size;
        got_a  = cmt_addr;
        got_d  = cmt_data;
        wr_en  = 1'b0;
    endtask

    task automatic expect_none(input string req);
        chk(req, "no commit", 128'(got_v), 128'(0));
    endtask

    task automatic expect_commit(input string req, input logic [1:0] sz,
                                 input logic [15:0] a, input logic [127:0] d);
        chk(req, "strobe", 128'(got_v), 128'(1));
        chk(req, "size",   128'(got_sz), 128'(sz));
        chk(req, "addr",   128'(got_a), 128'(a));
        chk(req, "data",   got_d, d);
    endtask

    // R10: strobe drops on the following idle cycle
    task automatic expect_idle_after(input string req);
        @(negedge clk);
        chk(req, "strobe after idle cycle", 128'(cmt_valid), 128'(0));
    endtask

    task automatic t_reset;
        chk("R1", "valid in reset state", 128'(cmt_valid), 128'(0));
        chk("R1", "data in reset state", cmt_data, 128'(0));
        wr(16'h083C, 32'hA1A1_0001);
        expect_commit("R1", 2'd2, 16'h0830, {32'hA1A1_0001, 96'h0});
    endtask

    task automatic t_csr_any_order;
        wr(16'h0108, 32'h2222_0002); expect_none("R2");
        wr(16'h0100, 32'h2222_0000); expect_none("R2");
        wr(16'h010C, 32'h2222_0003); expect_none("R2");
        wr(16'h0104, 32'h2222_0001);
        expect_commit("R2", 2'd2, 16'h0100,
                      {32'h2222_0003, 32'h2222_0002, 32'h2222_0001, 32'h2222_0000});
        expect_idle_after("R10");
    endtask

    task automatic t_mem_word;
        wr(16'hF00C, 32'h3333_0001); expect_none("R3");
        wr(16'hF008, 32'h3333_0000);
        expect_commit("R3", 2'd1, 16'hF008, {64'h0, 32'h3333_0001, 32'h3333_0000});
    endtask

    task automatic t_plain;
        wr(16'h2000, 32'h4444_0000);
        expect_commit("R4", 2'd0, 16'h2000, {96'h0, 32'h4444_0000});
        wr(16'h0040, 32'h4444_1000); expect_none("R4");
        wr(16'h1234, 32'h4444_2000);
        expect_commit("R4", 2'd0, 16'h1234, {96'h0, 32'h4444_2000});
        wr(16'h0044, 32'h4444_1001); expect_none("R4");
        wr(16'h0048, 32'h4444_1002); expect_none("R4");
        wr(16'h004C, 32'h4444_1003);
        expect_commit("R4", 2'd2, 16'h0040,
                      {32'h4444_1003, 32'h4444_1002, 32'h4444_1001, 32'h4444_1000});
    endtask

    task automatic t_restart;
        wr(16'h0200, 32'h5555_0000); expect_none("R5");
        wr(16'h0204, 32'h5555_0001); expect_none("R5");
        wr(16'h0210, 32'h5555_1000); expect_none("R5");
        wr(16'h0214, 32'h5555_1001); expect_none("R5");
        wr(16'h0218, 32'h5555_1002); expect_none("R5");
        wr(16'h021C, 32'h5555_1003);
        expect_commit("R5", 2'd2, 16'h0210,
                      {32'h5555_1003, 32'h5555_1002, 32'h5555_1001, 32'h5555_1000});
        wr(16'h0208, 32'h5555_2002); expect_none("R5");
        wr(16'h020C, 32'h5555_2003); expect_none("R5");
        wr(16'h0200, 32'h5555_2000); expect_none("R5");
        wr(16'h0204, 32'h5555_2001);
        expect_commit("R5", 2'd2, 16'h0200,
                      {32'h5555_2003, 32'h5555_2002, 32'h5555_2001, 32'h5555_2000});
    endtask

    task automatic t_desc_full;
        wr(16'h2A10, 32'h6666_0000); expect_none("R6");
        wr(16'h2A18, 32'h6666_0002); expect_none("R6");
        wr(16'h2A14, 32'h6666_0001); expect_none("R6");
        wr(16'h2A1C, 32'h6666_0003);
        expect_commit("R6", 2'd2, 16'h2A10,
                      {32'h6666_0003, 32'h6666_0002, 32'h6666_0001, 32'h6666_0000});
        wr(16'hE830, 32'h6666_1000); expect_none("R11");
        wr(16'hE834, 32'h6666_1001); expect_none("R11");
        wr(16'hE838, 32'h6666_1002); expect_none("R11");
        wr(16'hE83C, 32'h6666_1003);
        expect_commit("R11", 2'd2, 16'hE830,
                      {32'h6666_1003, 32'h6666_1002, 32'h6666_1001, 32'h6666_1000});
    endtask

    task automatic t_desc_partial;
        wr(16'h4830, 32'h7777_0000); expect_none("R7");
        wr(16'h4838, 32'h7777_0002); expect_none("R7");
        wr(16'h483C, 32'h7777_0003);
        expect_commit("R7", 2'd2, 16'h4830, {32'h7777_0003, 96'h0});
        wr(16'h4834, 32'h7777_0001); expect_none("R7");
        wr(16'h483C, 32'h7777_0013);
        expect_commit("R7", 2'd2, 16'h4830, {32'h7777_0013, 96'h0});
    endtask

    task automatic t_desc_drop;
        wr(16'h0300, 32'h8888_0000); expect_none("R8");
        wr(16'h0304, 32'h8888_0001); expect_none("R8");
        wr(16'h0830, 32'hDEAD_BEEF); expect_none("R8");
        wr(16'h0308, 32'h8888_0002); expect_none("R8");
        wr(16'h030C, 32'h8888_0003);
        expect_commit("R8", 2'd2, 16'h0300,
                      {32'h8888_0003, 32'h8888_0002, 32'h8888_0001, 32'h8888_0000});
        wr(16'h083C, 32'h8888_1003);
        expect_commit("R8", 2'd2, 16'h0830, {32'h8888_1003, 96'h0});
    endtask

    task automatic t_timer;
        wr(16'h0380, 32'h9999_0000); expect_none("R9");
        wr(16'h0384, 32'h9999_0001); expect_none("R9");
        wr(16'h0388, 32'h9999_0002); expect_none("R9");
        wr(16'h0420, 32'h9999_7777);
        expect_commit("R9", 2'd0, 16'h0420, {96'h0, 32'h9999_7777});
        wr(16'h038C, 32'h9999_0003); expect_none("R9");
        wr(16'h0380, 32'h9999_1000); expect_none("R9");
        wr(16'h0384, 32'h9999_1001); expect_none("R9");
        wr(16'h0388, 32'h9999_1002);
        expect_commit("R9", 2'd2, 16'h0380,
                      {32'h9999_0003, 32'h9999_1002, 32'h9999_1001, 32'h9999_1000});
        wr(16'h03C0, 32'h9999_2000); expect_none("R9");
        wr(16'h03C4, 32'h9999_2001); expect_none("R9");
        wr(16'h03C8, 32'h9999_2002); expect_none("R9");
        wr(16'h2420, 32'h9999_8888);
        expect_commit("R9", 2'd0, 16'h2420, {96'h0, 32'h9999_8888});
        wr(16'h03CC, 32'h9999_2003);
        expect_commit("R9", 2'd2, 16'h03C0,
                      {32'h9999_2003, 32'h9999_2002, 32'h9999_2001, 32'h9999_2000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr_any_order();
        t_mem_word();
        t_plain();
        t_restart();
        t_desc_full();
        t_desc_partial();
        t_desc_drop();
        t_timer();
        expect_idle_after("R10");
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule